// File: doc/BRIEF.md
# I2C Command-Byte Monitor Controller

This block is the two-wire serial slave front end of a voltage and current monitor. It runs on the system clock and oversamples the clock and data lines. It answers one 7-bit device address and accepts a single command byte after that address. The command byte programs a small control register. That register decides which conversions are requested from an external ADC sequencer through a one-cycle request and done handshake.

A master can do three things:
- probe for the device with an address-only transfer;
- write a command byte;
- read back either the latest 12-bit result (two bytes) or an 8-bit status byte.

While a one-shot conversion is outstanding, the read address is refused. A command byte with its top bit set is treated as an extended write. It is only flagged for another path and does not touch the control register.

Top module: `i2c_cmd_monitor`

## Requirements
- R1: After reset, the control register reads 0, range_sel is 0, conv_req is 0 and the block does not pull SDA low.
- R2: The block acknowledges its own address with the write bit (a start, address, write bit, then stop is enough to probe it). It leaves any other address unacknowledged.
- R3: A command byte with bit 7 = 0 is acknowledged and copied into the control register (bits 6:0). Bit 0 is continuous voltage, bit 1 is one-shot voltage, bit 2 is continuous current, bit 3 is one-shot current, bit 4 is the range select, bit 5 is unused and bit 6 is the status select.
- R4: A command byte with bit 7 = 1 is acknowledged and raises ext_write for exactly one clock. The control register keeps its value.
- R5: A one-shot bit (1 or 3) clears itself when conv_done returns for the conversion it requested.
- R6: While control bit 1 or bit 3 is set, the block answers a read address with no acknowledge.
- R7: With bit 6 = 0, a read returns the result as two bytes, MSB byte first. The first byte is 4'b0000 followed by result[11:8], and the second byte is result[7:0].
- R8: Every normal command write discards the previous result. A read before the next conversion completes is acknowledged and returns zeros.
- R9: range_sel always equals control bit 4.
- R10: With bit 6 = 1, a read returns the status_in byte as a single byte.
- R11: One-shot requests are issued before continuous ones, voltage before current. When both continuous bits are set, the channels alternate, starting with voltage (conv_chan 0 = voltage, 1 = current).
- R12: conv_req is a single-cycle pulse, and no new request is issued while a conversion is outstanding.
- R13: A STOP in the middle of a byte abandons the transfer without changing the control register, and the next transfer decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | When 1, the pad pulls SDA low |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 1 | Channel of the request: 0 voltage, 1 current |
| conv_done | input | 1 | One-cycle pulse, the conversion has finished |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| status_in | input | 8 | Alert status byte returned in status mode |
| range_sel | output | 1 | Static attenuator select to the analog side |
| ext_write | output | 1 | One-cycle flag for an extended command byte |
| ctrl_q | output | 7 | Current control register |

## Verification
The serial engine is driven with:
- a matching probe and a foreign-address probe, which separate address decode from acknowledge timing;
- a normal and an extended command byte, which separate the register load from the flag path;
- a command aborted by STOP.

Reads are issued in three situations: against a pending one-shot conversion, before and after the first continuous result, and in status mode. These show the acknowledge gate, the zero fill and the byte mux working independently of each other. The request log from the ADC model, taken after a mixed one-shot and continuous command and after a both-channel continuous command, tells the priority order apart from the alternation.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } bus_state_t;

  localparam int B_VCONT = 0;
  localparam int B_VONE  = 1;
  localparam int B_ICONT = 2;
  localparam int B_IONE  = 3;
  localparam int B_RANGE = 4;
  localparam int B_STAT  = 6;
  localparam int B_EXT   = 7;

  localparam logic CHAN_V = 1'b0;
  localparam logic CHAN_I = 1'b1;
endpackage

// File: rtl/mon_line_filter.sv
module mon_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      cnt_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (synced == dout) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        dout  <= synced;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mon_i2c_engine.sv
module mon_i2c_engine
  import i2c_mon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl,
  input  logic        sda,
  input  logic        rd_ok,
  input  logic [15:0] rd_word,
  input  logic        rd_two,
  output logic        sda_low,
  output logic        cmd_wr,
  output logic [7:0]  cmd_byte
);
  bus_state_t  state_q;
  logic        scl_d, sda_d;
  logic [3:0]  cnt_q;
  logic [7:0]  sh_q, tx_q;
  logic [15:0] word_q;
  logic        two_q, rw_q, second_q, more_q;
  logic        scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  assign start_det = scl & scl_d & sda_d & ~sda;
  assign stop_det  = scl & scl_d & ~sda_d & sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      word_q   <= '0;
      two_q    <= 1'b0;
      rw_q     <= 1'b0;
      second_q <= 1'b0;
      more_q   <= 1'b0;
      sda_low  <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_byte <= '0;
    end else begin
      scl_d  <= scl;
      sda_d  <= sda;
      cmd_wr <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        sda_low <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        sda_low <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (sh_q[7:1] == DEV_ADDR && (!sh_q[0] || rd_ok)) begin
                sda_low <= 1'b1;
                rw_q    <= sh_q[0];
                word_q  <= rd_word;
                two_q   <= rd_two;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q     <= word_q[15:8];
                sda_low  <= ~word_q[15];
                second_q <= 1'b0;
                state_q  <= ST_TX;
              end else begin
                sda_low <= 1'b0;
                state_q <= ST_CMD;
              end
            end
          end
          ST_CMD: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              sda_low  <= 1'b1;
              cmd_wr   <= 1'b1;
              cmd_byte <= sh_q;
              state_q  <= ST_CMD_ACK;
            end
          end
          ST_CMD_ACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              state_q <= ST_SKIP;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_low <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                tx_q    <= {tx_q[6:0], 1'b0};
                sda_low <= ~tx_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              more_q <= ~sda;
            end else if (scl_fall) begin
              if (more_q && two_q && !second_q) begin
                second_q <= 1'b1;
                tx_q     <= word_q[7:0];
                sda_low  <= ~word_q[7];
                cnt_q    <= '0;
                state_q  <= ST_TX;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R13
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_low && state_q == ST_IDLE));

  // R6
  nack_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && scl_fall && cnt_q == 4'd8 && sh_q[0] && !rd_ok)
      |=> !sda_low);
endmodule

// File: rtl/mon_conv_sched.sv
module mon_conv_sched
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_byte,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [6:0]        ctrl_q,
  output logic              ext_write,
  output logic              conv_req,
  output logic              conv_chan,
  output logic              rd_ok,
  output logic [DATA_W-1:0] result
);
  logic              busy_q, once_q, valid_q, alt_q;
  logic [DATA_W-1:0] res_q;
  logic              pick_valid, pick_once, pick_chan, finish;

  assign finish = busy_q & conv_done;
  assign rd_ok  = ~(ctrl_q[B_VONE] | ctrl_q[B_IONE]);
  assign result = valid_q ? res_q : '0;

  always_comb begin
    pick_valid = 1'b1;
    pick_once  = 1'b0;
    pick_chan  = CHAN_V;
    if (ctrl_q[B_VONE]) begin
      pick_once = 1'b1;
    end else if (ctrl_q[B_IONE]) begin
      pick_once = 1'b1;
      pick_chan = CHAN_I;
    end else if (ctrl_q[B_VCONT] && ctrl_q[B_ICONT]) begin
      pick_chan = alt_q;
    end else if (ctrl_q[B_ICONT]) begin
      pick_chan = CHAN_I;
    end else if (!ctrl_q[B_VCONT]) begin
      pick_valid = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ext_write <= 1'b0;
      conv_req  <= 1'b0;
      conv_chan <= CHAN_V;
      busy_q    <= 1'b0;
      once_q    <= 1'b0;
      valid_q   <= 1'b0;
      alt_q     <= CHAN_V;
      res_q     <= '0;
    end else begin
      conv_req  <= 1'b0;
      ext_write <= 1'b0;
      if (finish) begin
        busy_q  <= 1'b0;
        res_q   <= conv_data;
        valid_q <= 1'b1;
        if (once_q && !cmd_wr) begin
          ctrl_q[conv_chan ? B_IONE : B_VONE] <= 1'b0;
        end
      end
      if (cmd_wr) begin
        if (cmd_byte[B_EXT]) begin
          ext_write <= 1'b1;
        end else begin
          ctrl_q  <= cmd_byte[6:0];
          valid_q <= 1'b0;
          once_q  <= 1'b0;
        end
      end else if (!busy_q && pick_valid) begin
        conv_req  <= 1'b1;
        conv_chan <= pick_chan;
        busy_q    <= 1'b1;
        once_q    <= pick_once;
        if (!pick_once && ctrl_q[B_VCONT] && ctrl_q[B_ICONT]) begin
          alt_q <= ~pick_chan;
        end
      end
    end
  end

  // R12
  conv_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  // R12
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !conv_done) |=> !conv_req);

  // R4
  ext_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_byte[B_EXT] && !finish) |=> $stable(ctrl_q));

  // R5
  once_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (finish && once_q && !cmd_wr) |=> !(conv_chan ? ctrl_q[B_IONE] : ctrl_q[B_VONE]));
endmodule

// File: rtl/i2c_cmd_monitor.sv
module i2c_cmd_monitor
  import i2c_mon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4A,
  parameter int         DATA_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic              conv_req,
  output logic              conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [7:0]        status_in,
  output logic              range_sel,
  output logic              ext_write,
  output logic [6:0]        ctrl_q
);
  localparam int WORD_W = 16;
  localparam int PAD_W  = WORD_W - DATA_W;

  logic [1:0]        raw_lines, clean_lines;
  logic              rd_ok, cmd_wr;
  logic [7:0]        cmd_byte;
  logic [DATA_W-1:0] result;
  logic [WORD_W-1:0] rd_word;
  logic              rd_two;

  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    mon_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(clean_lines[g])
    );
  end

  assign rd_two  = ~ctrl_q[B_STAT];
  assign rd_word = ctrl_q[B_STAT] ? {status_in, 8'h00} : {{PAD_W{1'b0}}, result};

  mon_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .scl     (clean_lines[1]),
    .sda     (clean_lines[0]),
    .rd_ok   (rd_ok),
    .rd_word (rd_word),
    .rd_two  (rd_two),
    .sda_low (sda_drive_low),
    .cmd_wr  (cmd_wr),
    .cmd_byte(cmd_byte)
  );

  mon_conv_sched #(.DATA_W(DATA_W)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_byte (cmd_byte),
    .conv_done(conv_done),
    .conv_data(conv_data),
    .ctrl_q   (ctrl_q),
    .ext_write(ext_write),
    .conv_req (conv_req),
    .conv_chan(conv_chan),
    .rd_ok    (rd_ok),
    .result   (result)
  );

  assign range_sel = ctrl_q[B_RANGE];
endmodule

// File: tb/i2c_cmd_monitor_bench.sv
module i2c_cmd_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 20;
  localparam int ADC_LAT    = 4000;
  localparam int WD_CYCLES  = 190000;
  localparam logic [6:0] ADDR = 7'h4A;
  localparam logic [11:0] V_VAL = 12'hA5C;
  localparam logic [11:0] I_VAL = 12'h3B7;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_drive_low, conv_req, conv_chan, conv_done, range_sel, ext_write;
  logic [11:0] conv_data;
  logic [7:0]  status_in = 8'hC3;
  logic [6:0]  ctrl_q;
  logic        sda_bus;

  int errors = 0, checks = 0, ext_cnt = 0, done_cnt = 0, overlap_err = 0;
  int adc_left = 0;
  logic adc_busy = 1'b0, adc_chan = 1'b0;
  bit chan_log[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_drive_low;

  i2c_cmd_monitor u_i2c_cmd_monitor (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .status_in(status_in),
    .range_sel(range_sel), .ext_write(ext_write), .ctrl_q(ctrl_q)
  );

  // Behavioural ADC and per-clock observation of the request handshake.
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (rst) begin
      adc_busy <= 1'b0;
      conv_data <= '0;
    end else begin
      if (ext_write) ext_cnt++;
      if (conv_req) begin
        if (adc_busy) overlap_err++;   // R12
        adc_busy <= 1'b1;
        adc_chan <= conv_chan;
        adc_left <= ADC_LAT;
        chan_log.push_back(conv_chan);
      end else if (adc_busy) begin
        if (adc_left == 1) begin
          adc_busy  <= 1'b0;
          conv_done <= 1'b1;
          conv_data <= adc_chan ? I_VAL : V_VAL;
          done_cnt++;
        end
        adc_left <= adc_left - 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (QTR) @(posedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(last);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    bus_start(); put_byte({a, 1'b0}, ack); bus_stop();
  endtask

  task automatic wr_cmd(input logic [7:0] c, output logic a1, output logic a2);
    bus_start(); put_byte({ADDR, 1'b0}, a1);
    a2 = 1'b1;
    if (!a1) put_byte(c, a2);
    bus_stop();
  endtask

  task automatic rd_txn(input int n, output logic ack, output logic [7:0] b0, output logic [7:0] b1);
    b0 = 8'hEE; b1 = 8'hEE;
    bus_start(); put_byte({ADDR, 1'b1}, ack);
    if (!ack) begin
      get_byte(n == 1, b0);
      if (n == 2) get_byte(1'b1, b1);
    end
    bus_stop();
  endtask

  task automatic wait_adc_idle();
    for (int i = 0; i < 20000 && (adc_busy || conv_req); i++) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a1, a2, ack;
    logic [7:0] b0, b1;
    int base;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 range", range_sel, 0);
    chk("R1 sda", sda_drive_low, 0);
    chk("R1 req", conv_req, 0);

    // R2 probe own and foreign address
    probe(ADDR, ack);      chk("R2 own ack", ack, 0);
    probe(7'h21, ack);     chk("R2 foreign nack", ack, 1);

    // R3 / R9 normal command, range bit
    wr_cmd(8'h10, a1, a2);
    @(negedge clk);
    chk("R3 ack", {a1, a2}, 0);
    chk("R3 ctrl", ctrl_q, 7'h10);
    chk("R9 range", range_sel, 1);
    chk("R3 no conversion", chan_log.size(), 0);

    // R4 extended write
    wr_cmd(8'h85, a1, a2);
    @(negedge clk);
    chk("R4 ack", a2, 0);
    chk("R4 pulse count", ext_cnt, 1);
    chk("R4 ctrl kept", ctrl_q, 7'h10);

    // R13 STOP inside command byte
    bus_start(); put_byte({ADDR, 1'b0}, a1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    @(negedge clk);
    chk("R13 ctrl kept", ctrl_q, 7'h10);
    probe(ADDR, ack);      chk("R13 next ack", ack, 0);

    // R6 / R5 / R7 one-shot voltage
    wr_cmd(8'h02, a1, a2);
    rd_txn(2, ack, b0, b1);
    chk("R6 nack pending", ack, 1);
    for (int i = 0; i < 20000 && ctrl_q[1]; i++) @(posedge clk);
    @(negedge clk);
    chk("R5 self clear", ctrl_q, 7'h00);
    chk("R9 range follows", range_sel, 0);
    rd_txn(2, ack, b0, b1);
    chk("R7 ack", ack, 0);
    chk("R7 msb byte", b0, 8'h0A);
    chk("R7 lsb byte", b1, 8'h5C);
    wait_adc_idle();

    // R8 continuous: zeros before first result, then data
    base = done_cnt;
    wr_cmd(8'h01, a1, a2);
    rd_txn(2, ack, b0, b1);
    chk("R8 ack", ack, 0);
    chk("R8 zero data", {b0, b1}, 16'h0000);
    for (int i = 0; i < 20000 && done_cnt == base; i++) @(posedge clk);
    rd_txn(2, ack, b0, b1);
    chk("R8 data after", {b0, b1}, 16'h0A5C);

    // R10 status read
    wr_cmd(8'h40, a1, a2);
    rd_txn(1, ack, b0, b1);
    chk("R10 ack", ack, 0);
    chk("R10 status", b0, 8'hC3);
    wait_adc_idle();

    // R11 one-shot current ahead of continuous voltage
    chan_log.delete();
    base = done_cnt;
    wr_cmd(8'h09, a1, a2);
    for (int i = 0; i < 40000 && done_cnt < base + 3; i++) @(posedge clk);
    @(negedge clk);
    chk("R11 first is current", chan_log[0], 1);
    chk("R11 then voltage", chan_log[1], 0);
    chk("R11 voltage again", chan_log[2], 0);
    chk("R5 current one-shot cleared", ctrl_q, 7'h01);
    wr_cmd(8'h00, a1, a2);
    wait_adc_idle();

    // R11 alternation when both continuous bits are set
    chan_log.delete();
    base = done_cnt;
    wr_cmd(8'h05, a1, a2);
    for (int i = 0; i < 40000 && done_cnt < base + 3; i++) @(posedge clk);
    chk("R11 alt 0", chan_log[0], 0);
    chk("R11 alt 1", chan_log[1], 1);
    chk("R11 alt 2", chan_log[2], 0);
    wr_cmd(8'h00, a1, a2);
    wait_adc_idle();

    // R12 overlap observed every clock
    chk("R12 no overlapping request", overlap_err, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule